// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block is a small word-indexed register file. It reports the state of a memory-card slot to software. Two words hold fixed constants: an identification value and an address-decode value. A third word is a programming-control word that always reads zero. The fourth word is the slot status word. Its bit 0 follows the write-protect switch level at all times. Its bit 3 is a sticky card-inserted flag.

The card-inserted flag is set whenever the card-detect input is high. It stays set after the input falls, and it drives the interrupt output directly. Software acknowledges the event by writing a one to bit 3 of the status word. If the card-detect input is still high at that moment, the set wins and the flag stays set.

Both slot inputs are asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops before it reaches the status logic. The bus side is a single-cycle request with a registered read port. Read data appears one cycle after the request, marked by a one-cycle valid pulse.

Top module: `slot_ctrl_regs`

## Requirements
- R1: A read of word index 0 returns 0x41034003, and a read of word index 3 returns 0x00000011.
- R2: A read of word index 1 returns zero. Writes to index 1 or index 3 change no readable value and do not change the interrupt output.
- R3: For a read request (`bus_req`=1, `bus_we`=0), `rd_data` and a one-cycle `rd_valid` pulse appear on the next clock edge. A write request never raises `rd_valid`.
- R4: Bit 0 of the status word (index 2) follows the write-protect input level. It follows both rising and falling levels, within SYNC_STAGES+1 cycles, and it never latches.
- R5: Bit 3 of the status word is set while the card-detect input is high, and it stays set after the input falls.
- R6: A write to index 2 with bit 3 of the write data at 1 clears the card flag. A write to index 2 with bit 3 at 0 leaves the card flag unchanged, even when all other bits are 1. Bit 0 cannot be written.
- R7: The interrupt output `irq_o` always equals the card flag that a status read returns.
- R8: If a clear is written while the synchronized card-detect input is high, the card flag stays set and `irq_o` stays high.
- R9: After reset, the card flag and `irq_o` are 0 and `rd_valid` is 0. Reads of any index from 4 to 2^IDX_W-1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_idx | input | IDX_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| wprot_in | input | 1 | Write-protect switch level (asynchronous) |
| card_in | input | 1 | Card-detect level (asynchronous) |
| irq_o | output | 1 | Card-event interrupt |

## Verification
The bench goes after the following corner cases:

- **Stickiness.** The card flag must stay set after the detect input drops. A design that mirrors the level instead would lose the event, and `irq_o` would fall on its own.
- **Write data masking.** A status write with every bit set except bit 3 must clear nothing. A design that clears on any write to index 2 would drop the interrupt too early.
- **Clear against a high input.** A clear written while the input is still high must leave the flag set. A design that gives the clear priority would show a false gap in the interrupt.
- **Live write-protect bit.** The write-protect bit must follow the input in both directions. A design that latches it would keep reporting a removed protection.
- **Read-only and unmapped words.** Writes to the read-only words must leave every value unchanged. Unmapped indices must read zero, which catches a decode that aliases the upper indices.

// File: rtl/slot_ctrl_pkg.sv
package slot_ctrl_pkg;
  localparam int unsigned IDX_IDENT  = 0;
  localparam int unsigned IDX_PROG   = 1;
  localparam int unsigned IDX_STATUS = 2;
  localparam int unsigned IDX_DECODE = 3;
  // bit positions read by software drivers
  localparam int unsigned WP_BIT  = 0;
  localparam int unsigned CIN_BIT = 3;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/slot_status.sv
module slot_status (
  input  logic clk,
  input  logic rst,
  input  logic wp_s,
  input  logic cin_s,
  input  logic clr_i,
  output logic wp_q,
  output logic cin_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= 1'b0;
      cin_q <= 1'b0;
    end else begin
      wp_q  <= wp_s;
      // set has priority over clear
      cin_q <= (cin_q & ~clr_i) | cin_s;
    end
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cin_q && !clr_i) |=> cin_q);
  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !cin_s) |=> !cin_q);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cin_s |=> cin_q);
endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
  import slot_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 4,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_VALUE = 32'h0000_0011
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wp_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] status_w;

  always_comb begin
    status_w          = '0;
    status_w[WP_BIT]  = wp_i;
    status_w[CIN_BIT] = cin_i;
  end

  always_comb begin
    val_o = '0;
    if (idx_i == IDX_W'(IDX_IDENT))       val_o = ID_VALUE;
    else if (idx_i == IDX_W'(IDX_STATUS)) val_o = status_w;
    else if (idx_i == IDX_W'(IDX_DECODE)) val_o = DEC_VALUE;
    // programming word and unmapped words read zero
  end
endmodule

// File: rtl/slot_ctrl_regs.sv
module slot_ctrl_regs
  import slot_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              wprot_in,
  input  logic              card_in,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << CIN_BIT;

  logic wp_s, cin_s, wp_q, cin_q, clr;
  logic rd_req;
  logic [DATA_W-1:0] mux_val;

  slot_sync #(.STAGES(SYNC_STAGES)) u_sync_wp (
    .clk(clk), .rst(rst), .d(wprot_in), .q(wp_s));
  slot_sync #(.STAGES(SYNC_STAGES)) u_sync_cin (
    .clk(clk), .rst(rst), .d(card_in), .q(cin_s));

  assign clr    = bus_req & bus_we & (bus_idx == IDX_W'(IDX_STATUS))
                  & (|(bus_wdata & CLR_MASK));
  assign rd_req = bus_req & ~bus_we;

  slot_status u_status (
    .clk(clk), .rst(rst), .wp_s(wp_s), .cin_s(cin_s), .clr_i(clr),
    .wp_q(wp_q), .cin_q(cin_q));

  slot_read_mux #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .ID_VALUE(ID_VALUE), .DEC_VALUE(DEC_VALUE)
  ) u_mux (
    .idx_i(bus_idx), .wp_i(wp_q), .cin_i(cin_q), .val_o(mux_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= mux_val;
    end
  end

  assign irq_o = cin_q;

  // R1
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_idx == IDX_W'(IDX_IDENT)) |=> rd_data == ID_VALUE);
  // R2
  prog_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_idx == IDX_W'(IDX_PROG)) |=> rd_data == '0);
  // R3
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  // R3
  no_wr_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_idx == IDX_W'(IDX_STATUS)) |=> rd_data[CIN_BIT] == $past(irq_o));
endmodule

// File: tb/slot_ctrl_regs_test.sv
module slot_ctrl_regs_test;
  localparam int unsigned DW = 32;
  localparam int unsigned IW = 4;
  localparam int unsigned NV = 16;
  localparam logic [31:0] ID_C  = 32'h4103_4003;
  localparam logic [31:0] DEC_C = 32'h0000_0011;
  // {index, expected read} after reset with both inputs low
  localparam logic [35:0] VEC [NV] = '{
    {4'd0, ID_C}, {4'd1, 32'h0}, {4'd2, 32'h0}, {4'd3, DEC_C},
    {4'd4, 32'h0}, {4'd5, 32'h0}, {4'd6, 32'h0}, {4'd7, 32'h0},
    {4'd8, 32'h0}, {4'd9, 32'h0}, {4'd10, 32'h0}, {4'd11, 32'h0},
    {4'd12, 32'h0}, {4'd13, 32'h0}, {4'd14, 32'h0}, {4'd15, 32'h0}};

  logic clk = 0, rst = 1;
  logic bus_req = 0, bus_we = 0;
  logic [IW-1:0] bus_idx = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, wprot_in = 0, card_in = 0, irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slot_ctrl_regs uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .wprot_in(wprot_in), .card_in(card_in), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [IW-1:0] i, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_idx = i; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    chk("R3 no valid on write", {31'b0, rd_valid}, 32'h0);
  endtask

  task automatic rd(input logic [IW-1:0] i, output logic [31:0] v);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_idx = i;
    @(negedge clk);
    bus_req = 0;
    chk("R3 read valid", {31'b0, rd_valid}, 32'h1);
    v = rd_data;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R9 valid after reset", {31'b0, rd_valid}, 32'h0);
    for (int k = 0; k < NV; k++) begin
      rd(VEC[k][35:32], v);
      chk("R1/R2/R9 table read", v, VEC[k][31:0]);
    end
    // R4 write-protect follows level both ways
    wprot_in = 1; settle();
    rd(4'd2, v); chk("R4 wp high", v, 32'h1);
    wprot_in = 0; settle();
    rd(4'd2, v); chk("R4 wp low", v, 32'h0);
    // R5 sticky card flag
    card_in = 1; settle();
    chk("R7 irq on insert", {31'b0, irq_o}, 32'h1);
    card_in = 0; settle();
    rd(4'd2, v); chk("R5 flag sticky", v, 32'h8);
    chk("R7 irq held", {31'b0, irq_o}, 32'h1);
    // R2 writes to read-only words
    wr(4'd1, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R2 prog unchanged", v, 32'h0);
    rd(4'd3, v); chk("R2 decode unchanged", v, DEC_C);
    rd(4'd2, v); chk("R2 status unchanged", v, 32'h8);
    chk("R2 irq unchanged", {31'b0, irq_o}, 32'h1);
    // R6 masked write does not clear
    wr(4'd2, 32'hFFFF_FFF7);
    rd(4'd2, v); chk("R6 no clear without bit3", v, 32'h8);
    // R6 clear
    wr(4'd2, 32'h0000_0008);
    chk("R7 irq after clear", {31'b0, irq_o}, 32'h0);
    rd(4'd2, v); chk("R6 cleared", v, 32'h0);
    // R8 clear while input high
    card_in = 1; settle();
    wr(4'd2, 32'h0000_0008);
    chk("R8 irq stays", {31'b0, irq_o}, 32'h1);
    rd(4'd2, v); chk("R8 flag stays", v, 32'h8);
    card_in = 0; settle();
    wr(4'd2, 32'h0000_0009);
    rd(4'd2, v); chk("R6 final clear", v, 32'h0);
    // R9 reset clears flag
    card_in = 1; settle(); card_in = 0; settle();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R9 irq reset", {31'b0, irq_o}, 32'h0);
    rd(4'd2, v); chk("R9 flag reset", v, 32'h0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule